// File: doc/BRIEF.md
# Dual-Master Address Bus Arbiter

This block decides which master may drive the address bus of a split-transaction processor bus. Three masters share it: two external processors and one internal bridge master. Each processor has an active-low request and an active-low grant. The internal master uses an active-high request and an active-high grant. A master that holds a grant begins an address tenure by pulling the shared transfer-start line low. The arbiter ends that tenure with a one-cycle address acknowledge or with a one-cycle address retry.

When no master is requesting, the processor that last completed a tenure keeps its grant. That processor can then start a transfer without raising a request first. The internal master outranks both processors. When both processors request at once, the grant goes to the one that did not own the bus last. The acknowledge waits until the data bus grant for the tenure has been sampled. The next address grant is issued in the cycle after the acknowledge, so that the address phase can overlap the data phase that is still running.

A processor tenure that hits an internal buffer is retried, unless the external cache claims it. A tenure flagged as run by the cache controller is acknowledged early. In that case no new grant is issued until its data tenure has begun.

Top module: `addr_bus_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released with no input active, `bg_n` is 2'b11 and `int_gnt`, `aack` and `artry` are low. No processor is parked.
- R2: At most one grant is active at any time. `bg_n[0]` low grants processor 0 and `bg_n[1]` low grants processor 1. A request sampled while the bus is free is granted in the following cycle.
- R3: After a processor's tenure is acknowledged, and with no request pending, that processor's grant is reasserted one cycle after `aack`. Asserting `ts_n` under this parked grant starts a tenure without any request.
- R4: An internal request sampled while the bus is free, with no grant hold, produces `int_gnt` in the next cycle and removes any parked processor grant. An internal request that arrives during a tenure is granted only in the cycle after that tenure's `aack`.
- R5: A tenure starts when `ts_n` is sampled low under an active grant. All grants drop in the next cycle. `aack` is a one-cycle pulse in the cycle after `data_grant` is sampled high during the tenure. The next grant appears in the cycle after `aack`.
- R6: A tenure run by the internal master never receives `aack` unless `data_grant` was sampled in the cycle before. A buffer hit does not retry it.
- R7: When both processors request while the bus is free, the grant goes to the processor that did not complete the most recent acknowledged processor tenure. After reset, processor 0 wins the first tie.
- R8: A processor tenure with `buf_hit` high and `l2_claim` low in a cycle produces a one-cycle `artry` in the next cycle. That tenure then ends without `aack`.
- R9: A retried tenure does not change which processor wins the next tie.
- R10: A processor tenure with `buf_hit` and `l2_claim` both high is not retried. It completes with `aack` after `data_grant`.
- R11: A processor tenure started with `cache_run` high receives `aack` two cycles after the `ts_n` sample, without waiting for `data_grant`.
- R12: After such an early `aack`, no grant is issued until `data_grant` is sampled high. The next grant appears in the cycle after that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | 2 | Active-low processor requests (bit i is processor i) |
| int_req | input | 1 | Internal master request, active high |
| ts_n | input | 1 | Shared transfer start, active low |
| cache_run | input | 1 | Tenure being started is run by the external cache controller (sampled with `ts_n`) |
| data_grant | input | 1 | Data bus granted to the oldest unserved address tenure |
| buf_hit | input | 1 | Snoop hit in an internal buffer for the current tenure |
| l2_claim | input | 1 | External cache claims the current tenure |
| bg_n | output | 2 | Active-low processor address grants |
| int_gnt | output | 1 | Internal master address grant |
| aack | output | 1 | Address acknowledge pulse |
| artry | output | 1 | Address retry pulse |

## Verification
The checker enforces the following on every cycle:
- At most one grant is active.
- `aack` and `artry` never occur together.
- A free bus with an internal request and no hold leads to `int_gnt`.
- Internal tenures get no `aack` unless `data_grant` was sampled.
- An unclaimed processor hit produces `artry`, and a claimed hit never does.
- No grant is issued while an early-acknowledged data tenure has not yet started.

Some behaviours depend on history over several tenures, and only the directed scenarios can show them:
- Parking.
- Alternation between the processors.
- The fairness pointer staying put after a retry.
- The exact cycle on which a grant returns after `aack` or after the delayed `data_grant`.

// File: rtl/ab_pkg.sv
package ab_pkg;
  localparam int NUM_PROC = 2;

  typedef enum logic [1:0] {
    MST_NONE = 2'd0,
    MST_P0   = 2'd1,
    MST_P1   = 2'd2,
    MST_INT  = 2'd3
  } mst_e;

  function automatic mst_e proc_mst(input logic idx);
    return idx ? MST_P1 : MST_P0;
  endfunction

  function automatic logic is_proc(input mst_e m);
    return (m == MST_P0) || (m == MST_P1);
  endfunction

  function automatic logic proc_idx(input mst_e m);
    return m == MST_P1;
  endfunction

  // Priority: hold, internal, processor tie by fairness, single processor, park.
  function automatic mst_e pick_master(input logic hold, input logic int_rq,
                                       input logic [NUM_PROC-1:0] rq,
                                       input logic last, input logic park_ok);
    if (hold)    return MST_NONE;
    if (int_rq)  return MST_INT;
    if (&rq)     return proc_mst(~last);
    if (rq[0])   return MST_P0;
    if (rq[1])   return MST_P1;
    if (park_ok) return proc_mst(last);
    return MST_NONE;
  endfunction
endpackage

// File: rtl/ab_pick.sv
module ab_pick
  import ab_pkg::*;
(
  input  logic                hold,
  input  logic                int_req,
  input  logic [NUM_PROC-1:0] req_n,
  input  logic                last_proc,
  input  logic                park_ok,
  output mst_e                next_mst
);
  logic [NUM_PROC-1:0] req_act;

  assign req_act  = ~req_n;
  assign next_mst = pick_master(hold, int_req, req_act, last_proc, park_ok);
endmodule

// File: rtl/ab_park.sv
module ab_park
  import ab_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_ev,
  input  mst_e owner,
  output logic last_proc,
  output logic park_ok
);
  // Reset value 1 makes processor 0 win the first tie.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_proc <= 1'b1;
      park_ok   <= 1'b0;
    end else if (ack_ev && is_proc(owner)) begin
      last_proc <= proc_idx(owner);
      park_ok   <= 1'b1;
    end
  end
endmodule

// File: rtl/ab_tenure.sv
module ab_tenure
  import ab_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_ev,
  input  mst_e gnt,
  input  logic cache_run,
  input  logic data_grant,
  input  logic buf_hit,
  input  logic l2_claim,
  output logic busy,
  output mst_e owner,
  output logic dpend,
  output logic ack_ev,
  output logic retry_ev,
  output logic aack,
  output logic artry
);
  logic cache_q;

  assign retry_ev = busy && is_proc(owner) && buf_hit && !l2_claim;
  assign ack_ev   = busy && !retry_ev && (data_grant || cache_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      owner   <= MST_NONE;
      cache_q <= 1'b0;
      dpend   <= 1'b0;
      aack    <= 1'b0;
      artry   <= 1'b0;
    end else begin
      aack  <= ack_ev;
      artry <= retry_ev;
      if (start_ev) begin
        busy    <= 1'b1;
        owner   <= gnt;
        cache_q <= cache_run && is_proc(gnt);
      end else if (ack_ev || retry_ev) begin
        busy    <= 1'b0;
        cache_q <= 1'b0;
      end
      if (ack_ev && cache_q && !data_grant) dpend <= 1'b1;
      else if (data_grant)                  dpend <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_bus_arbiter.sv
module addr_bus_arbiter
  import ab_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PROC-1:0] req_n,
  input  logic                int_req,
  input  logic                ts_n,
  input  logic                cache_run,
  input  logic                data_grant,
  input  logic                buf_hit,
  input  logic                l2_claim,
  output logic [NUM_PROC-1:0] bg_n,
  output logic                int_gnt,
  output logic                aack,
  output logic                artry
);
  mst_e gnt_q;
  mst_e next_mst;
  mst_e owner;
  logic busy, dpend, ack_ev, retry_ev;
  logic last_proc, park_ok;
  logic hold, tenure_start;

  assign hold         = dpend && !data_grant;
  assign tenure_start = !busy && !ts_n && (gnt_q != MST_NONE);

  ab_pick u_pick (
    .hold(hold), .int_req(int_req), .req_n(req_n),
    .last_proc(last_proc), .park_ok(park_ok), .next_mst(next_mst)
  );

  ab_tenure u_ten (
    .clk(clk), .rst_n(rst_n), .start_ev(tenure_start), .gnt(gnt_q),
    .cache_run(cache_run), .data_grant(data_grant), .buf_hit(buf_hit),
    .l2_claim(l2_claim), .busy(busy), .owner(owner), .dpend(dpend),
    .ack_ev(ack_ev), .retry_ev(retry_ev), .aack(aack), .artry(artry)
  );

  ab_park u_park (
    .clk(clk), .rst_n(rst_n), .ack_ev(ack_ev), .owner(owner),
    .last_proc(last_proc), .park_ok(park_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                 gnt_q <= MST_NONE;
    else if (busy || tenure_start) gnt_q <= MST_NONE;
    else                        gnt_q <= next_mst;
  end

  for (genvar i = 0; i < NUM_PROC; i++) begin : g_bg
    assign bg_n[i] = !(gnt_q == proc_mst(1'(i)));
  end
  assign int_gnt = (gnt_q == MST_INT);
endmodule

// File: rtl/ab_checker.sv
module ab_checker
  import ab_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PROC-1:0] bg_n,
  input logic                int_gnt,
  input logic                aack,
  input logic                artry,
  input logic                int_req,
  input logic                data_grant,
  input logic                buf_hit,
  input logic                l2_claim,
  input logic                busy,
  input mst_e                owner,
  input logic                dpend,
  input logic                tenure_start
);
  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~bg_n, int_gnt}));

  // R8
  ack_retry_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(aack && artry));

  // R6
  int_ack_dgrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && owner == MST_INT && !data_grant) |=> !aack);

  // R12
  hold_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dpend && !data_grant) |=> (bg_n == '1 && !int_gnt));

  // R4
  int_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tenure_start && !(dpend && !data_grant) && int_req) |=> int_gnt);

  // R8
  retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_proc(owner) && buf_hit && !l2_claim) |=> (artry && !aack));

  // R10
  claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && buf_hit && l2_claim) |=> !artry);
endmodule

bind addr_bus_arbiter ab_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bg_n(bg_n), .int_gnt(int_gnt), .aack(aack),
  .artry(artry), .int_req(int_req), .data_grant(data_grant),
  .buf_hit(buf_hit), .l2_claim(l2_claim), .busy(busy), .owner(owner),
  .dpend(dpend), .tenure_start(tenure_start)
);

// File: tb/addr_bus_arbiter_test.sv
module addr_bus_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] req_n = 2'b11;
  logic       int_req = 1'b0, ts_n = 1'b1, cache_run = 1'b0;
  logic       data_grant = 1'b0, buf_hit = 1'b0, l2_claim = 1'b0;
  logic [1:0] bg_n;
  logic       int_gnt, aack, artry;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  // Observed vector {bg_n[1], bg_n[0], int_gnt, aack, artry}
  localparam logic [4:0] IDLE = 5'b11000, G0 = 5'b10000, G1 = 5'b01000,
                         GI = 5'b11100, ACK = 5'b11010, RTY = 5'b11001;

  always #5 clk = ~clk;

  addr_bus_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .int_req(int_req), .ts_n(ts_n),
    .cache_run(cache_run), .data_grant(data_grant), .buf_hit(buf_hit),
    .l2_claim(l2_claim), .bg_n(bg_n), .int_gnt(int_gnt), .aack(aack), .artry(artry)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string rq, input logic [4:0] exp);
    logic [4:0] obs;
    obs = {bg_n, int_gnt, aack, artry};
    checks++;
    if (obs !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", rq, obs, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) cyc();
    chk("R1 in reset", IDLE);
    rst_n = 1'b1;
    cyc(); chk("R1 no park after reset", IDLE);
  endtask

  task automatic t_first_tenure();
    req_n = 2'b10; cyc(); chk("R2 grant p0", G0);
    ts_n = 1'b0; req_n = 2'b11; cyc(); chk("R5 grant drops at start", IDLE);
    ts_n = 1'b1; cyc(); chk("R5 no aack without data grant", IDLE);
    data_grant = 1'b1; cyc(); chk("R5 aack after data grant", ACK);
    data_grant = 1'b0; cyc(); chk("R3 p0 parked after aack", G0);
  endtask

  task automatic t_park_start();
    ts_n = 1'b0; cyc(); chk("R3 parked start", IDLE);
    ts_n = 1'b1; data_grant = 1'b1; cyc(); chk("R3 parked tenure acked", ACK);
    data_grant = 1'b0; cyc(); chk("R3 park restored", G0);
  endtask

  task automatic t_internal();
    int_req = 1'b1; cyc(); chk("R4 internal removes parked grant", GI);
    int_req = 1'b0; cyc(); chk("R3 park back after internal drops", G0);
    int_req = 1'b1; ts_n = 1'b0; cyc(); chk("R4 p0 start wins same cycle", IDLE);
    ts_n = 1'b1; cyc(); chk("R4 internal waits for tenure", IDLE);
    data_grant = 1'b1; cyc(); chk("R5 p0 aack", ACK);
    data_grant = 1'b0; cyc(); chk("R4 internal granted after aack", GI);
    ts_n = 1'b0; cyc(); chk("R6 internal start", IDLE);
    ts_n = 1'b1; int_req = 1'b0; buf_hit = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cyc(); chk("R6 internal no aack and no retry", IDLE);
    end
    buf_hit = 1'b0; data_grant = 1'b1; cyc(); chk("R6 internal aack", ACK);
    data_grant = 1'b0; cyc(); chk("R3 park stays with p0", G0);
  endtask

  task automatic t_fair();
    req_n = 2'b00; cyc(); chk("R7 tie goes to p1", G1);
    ts_n = 1'b0; cyc(); chk("R7 p1 start", IDLE);
    ts_n = 1'b1; data_grant = 1'b1; cyc(); chk("R7 p1 aack", ACK);
    data_grant = 1'b0; cyc(); chk("R7 tie goes to p0", G0);
    ts_n = 1'b0; cyc(); chk("R7 p0 start", IDLE);
    ts_n = 1'b1; data_grant = 1'b1; cyc(); chk("R7 p0 aack", ACK);
    data_grant = 1'b0; cyc(); chk("R7 tie back to p1", G1);
  endtask

  task automatic t_retry();
    ts_n = 1'b0; cyc(); chk("R8 p1 start", IDLE);
    ts_n = 1'b1; buf_hit = 1'b1; l2_claim = 1'b0; cyc(); chk("R8 retry pulse", RTY);
    buf_hit = 1'b0; cyc(); chk("R9 tie still p1 after retry", G1);
  endtask

  task automatic t_claim();
    ts_n = 1'b0; cyc(); chk("R10 p1 start", IDLE);
    ts_n = 1'b1; buf_hit = 1'b1; l2_claim = 1'b1; cyc(); chk("R10 claimed hit no retry", IDLE);
    buf_hit = 1'b0; l2_claim = 1'b0; data_grant = 1'b1; cyc(); chk("R10 claimed acked", ACK);
    data_grant = 1'b0; req_n = 2'b11; cyc(); chk("R3 p1 parked", G1);
  endtask

  task automatic t_cache();
    ts_n = 1'b0; cache_run = 1'b1; cyc(); chk("R11 cache start", IDLE);
    ts_n = 1'b1; cache_run = 1'b0; req_n = 2'b10; cyc(); chk("R11 early aack", ACK);
    cyc(); chk("R12 held after early aack", IDLE);
    cyc(); chk("R12 still held", IDLE);
    data_grant = 1'b1; cyc(); chk("R12 grant after data grant", G0);
    data_grant = 1'b0; req_n = 2'b11;
  endtask

  initial begin
    t_reset();
    t_first_tenure();
    t_park_start();
    t_internal();
    t_fair();
    t_retry();
    t_claim();
    t_cache();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule